// File: doc/BRIEF.md
# Single-Wire Bus Master Timing Engine

This block generates the line timing for an open-drain single-wire bus with a pull-up resistor. On command it runs one of three primitive operations: a bus reset that listens for a presence response, a one-bit write slot, or a one-bit read slot. Each operation is timed in microseconds, counted from a 1 µs tick that is derived from the system clock frequency parameter. Byte assembly, device addressing and CRC handling belong to the layer that issues the commands.

A command consists of an operation code and a write value. It is handed over with a valid/ready handshake. The engine pulls the line low through `bus_pull_low` and sources current through `bus_drive_high`. It reads the line back through a two-flop synchronizer. When the operation is over, it pulses `done` for one cycle and presents `result` in that cycle. After a bus reset the idle line is actively driven high, so that parasite-powered devices can draw supply between slots.

Presence and read data are found by polling at 5 µs intervals, and polling stops at the first low sample. Write and read slots always take 64 µs. A bus reset ends 450 µs after its polling stops.

Top module: `swb_master`

## Requirements
- R1: While `rst_n` is low at a clock edge, the engine returns to idle: after that edge `cmd_ready`=1, `done`=0, `bus_pull_low`=0, `bus_drive_high`=0.
- R2: Operation codes are 2'b00 bus reset, 2'b01 write, 2'b10 read. A command with one of these codes is accepted at a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` stays low from that edge until the cycle in which `done` is high.
- R3: A command presented while the engine is busy has no effect. A command with code 2'b11 is never executed: it produces no `done`, no low pulse on the line and no change of drive state.
- R4: `done` is high for exactly one cycle per accepted command. `result` is valid in that cycle, and `cmd_ready` is high in that cycle.
- R5: All durations are whole multiples of D = CLK_HZ/1,000,000 clock cycles, counted from the acceptance edge. A bus reset pulls the line low for 500 µs and then releases it.
- R6: After the reset low phase, the line is sampled every 5 µs, at 505, 510, …, 740 µs. Polling stops at the first low sample and `result`=1 (device present). If none of the 48 samples is low, `result`=0.
- R7: A bus reset completes 450 µs after its polling stops. When sample k (1..48) is the first low sample, `done` occurs (950+5k)·D cycles after acceptance. When no sample is low, `done` occurs 1190·D cycles after acceptance.
- R8: After the first completed bus reset, the idle line is driven high. Before any bus reset completes, the idle line is released. During a reset or read operation the engine never drives high.
- R9: A write of 1 pulls the line low for 2 µs and drives it high for 62 µs. A write of 0 pulls it low for 62 µs and drives it high for 2 µs. `done` comes 64 µs after acceptance, with `result` equal to the written bit.
- R10: A read pulls the line low for 2 µs and then releases it. It samples at 7, 12, …, 42 µs and stops at the first low sample. `result` is 0 if any sample was low and 1 otherwise. `done` comes 64 µs after acceptance.
- R11: The line input passes through a two-flop synchronizer. A sample taken at clock edge E uses the level that was on `bus_in` before edge E-2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock at CLK_HZ |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Engine idle, command can be taken |
| cmd_op | input | 2 | Operation code (00 reset, 01 write, 10 read) |
| cmd_bit | input | 1 | Value for a write slot |
| done | output | 1 | One-cycle completion pulse |
| result | output | 1 | Presence flag, read bit or echoed write bit |
| bus_pull_low | output | 1 | Pull the bus line low |
| bus_drive_high | output | 1 | Actively source the bus line high |
| bus_in | input | 1 | Bus line level (asynchronous) |

## Verification
All latencies are counted from the acceptance edge. A write or read is due exactly 64·D cycles later. A bus reset is due (950+5k)·D cycles later with k the first low sample, or 1190·D cycles later when no device answers. The bench timestamps the acceptance edge with a free-running cycle counter and waits for `done` at the falling clock edge. It then compares the elapsed count and the low- and high-drive cycle counts with values its own functions compute. Those functions model a sample at edge E as seeing the bus level from before edge E-2 (the synchronizer depth), so device pulses are placed relative to that offset, including the one-cycle boundaries at the last poll of each window.

// File: rtl/swb_pkg.sv
// Package: shared operation codes and sequencer states for the single-wire
// bus master. Assumes a two-bit command code from the issuing layer.
package swb_pkg;

    typedef enum logic [1:0] {
        OP_BUS_RESET = 2'b00,
        OP_WRITE     = 2'b01,
        OP_READ      = 2'b10,
        OP_NONE      = 2'b11
    } swb_op_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RST_LOW,
        S_RST_POLL,
        S_RST_REC,
        S_WR_LOW,
        S_WR_HIGH,
        S_RD_LOW,
        S_RD_POLL,
        S_RD_PAD
    } swb_state_e;

endpackage

// File: rtl/swb_tick_gen.sv
// Module: 1 us enable generator. Divides CLK_HZ by one million; the phase
// restarts on clr so every operation is timed from its acceptance edge.
// Assumes CLK_HZ is a whole multiple of 1 MHz.
module swb_tick_gen #(
    parameter int CLK_HZ = 100_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int DIV   = CLK_HZ / 1_000_000;
    localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [DIV_W-1:0] LAST = DIV_W'(DIV - 1);

    logic [DIV_W-1:0] cnt;

    // Free-running divider, restarted by reset or by clr.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Tick is high during the last cycle of each microsecond.
    assign tick = (cnt == LAST);

endmodule

// File: rtl/swb_line_sync.sv
// Module: multi-flop synchronizer for the asynchronous bus input. Resets to
// the pulled-up (high) level so no false low is seen after reset.
module swb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_async,
    output logic line_sync
);
    logic [STAGES-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First stage captures the raw pin.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= 1'b1;
                    else        chain[0] <= line_async;
                end
            end else begin : g_next
                // Later stages settle metastability.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= 1'b1;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign line_sync = chain[STAGES-1];

endmodule

// File: rtl/swb_sequencer.sv
// Module: operation sequencer. Runs bus reset with presence polling, write
// slots and read slots, all counted in 1 us ticks. Assumes tick restarts on
// start so phase boundaries fall on whole microseconds after acceptance.
module swb_sequencer
    import swb_pkg::*;
#(
    parameter int T_RST_LOW  = 500,
    parameter int T_PRES_WIN = 240,
    parameter int T_RECOV    = 450,
    parameter int T_POLL     = 5,
    parameter int T_SHORT    = 2,
    parameter int T_SLOT     = 64,
    parameter int T_RD_WIN   = 45
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       line,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_op,
    input  logic       cmd_bit,
    output logic       cmd_ready,
    output logic       start,
    output logic       pull_low,
    output logic       drive_high,
    output logic       done,
    output logic       result
);
    localparam int PRES_POLLS = T_PRES_WIN / T_POLL;
    localparam int RD_POLLS   = (T_RD_WIN - T_SHORT) / T_POLL;
    localparam int OP_MAX     = T_RST_LOW + T_PRES_WIN + T_RECOV + T_SLOT;
    localparam int CW         = $clog2(OP_MAX + 1);
    localparam int POLL_MAX   = (PRES_POLLS > RD_POLLS) ? PRES_POLLS : RD_POLLS;
    localparam int PW         = $clog2(POLL_MAX + 1);

    localparam logic [CW-1:0] C_RST_LOW = CW'(T_RST_LOW - 1);
    localparam logic [CW-1:0] C_RECOV   = CW'(T_RECOV - 1);
    localparam logic [CW-1:0] C_POLL    = CW'(T_POLL - 1);
    localparam logic [CW-1:0] C_SHORT   = CW'(T_SHORT - 1);
    localparam logic [CW-1:0] C_LONG    = CW'(T_SLOT - T_SHORT - 1);
    localparam logic [CW-1:0] C_SLOT    = CW'(T_SLOT - 1);
    localparam logic [PW-1:0] C_PRES_LAST = PW'(PRES_POLLS - 1);
    localparam logic [PW-1:0] C_RD_LAST   = PW'(RD_POLLS - 1);

    swb_state_e    state;
    logic [CW-1:0] ph_cnt;
    logic [CW-1:0] op_us;
    logic [PW-1:0] poll_n;
    logic          wbit;
    logic          low_seen;
    logic          powered;

    assign cmd_ready = (state == S_IDLE);
    assign start     = cmd_valid && cmd_ready && (cmd_op != OP_NONE);

    // Main sequencing: command launch, phase timing, polling and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            ph_cnt   <= '0;
            op_us    <= '0;
            poll_n   <= '0;
            wbit     <= 1'b0;
            low_seen <= 1'b0;
            powered  <= 1'b0;
            done     <= 1'b0;
            result   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (state == S_IDLE) begin
                if (start) begin
                    ph_cnt   <= '0;
                    op_us    <= '0;
                    poll_n   <= '0;
                    wbit     <= cmd_bit;
                    low_seen <= 1'b0;
                    case (cmd_op)
                        OP_BUS_RESET: state <= S_RST_LOW;
                        OP_WRITE:     state <= S_WR_LOW;
                        default:      state <= S_RD_LOW;
                    endcase
                end
            end else if (tick) begin
                ph_cnt <= ph_cnt + 1'b1;
                op_us  <= op_us + 1'b1;
                case (state)
                    S_RST_LOW: if (ph_cnt == C_RST_LOW) begin
                        state  <= S_RST_POLL;
                        ph_cnt <= '0;
                    end
                    S_RST_POLL: if (ph_cnt == C_POLL) begin
                        ph_cnt <= '0;
                        poll_n <= poll_n + 1'b1;
                        if (!line) begin
                            low_seen <= 1'b1;
                            state    <= S_RST_REC;
                        end else if (poll_n == C_PRES_LAST) begin
                            state <= S_RST_REC;
                        end
                    end
                    S_RST_REC: if (ph_cnt == C_RECOV) begin
                        state   <= S_IDLE;
                        done    <= 1'b1;
                        result  <= low_seen;
                        powered <= 1'b1;
                    end
                    S_WR_LOW: if (ph_cnt == (wbit ? C_SHORT : C_LONG)) begin
                        state <= S_WR_HIGH;
                    end
                    S_WR_HIGH: if (op_us == C_SLOT) begin
                        state  <= S_IDLE;
                        done   <= 1'b1;
                        result <= wbit;
                    end
                    S_RD_LOW: if (ph_cnt == C_SHORT) begin
                        state  <= S_RD_POLL;
                        ph_cnt <= '0;
                    end
                    S_RD_POLL: if (ph_cnt == C_POLL) begin
                        ph_cnt <= '0;
                        poll_n <= poll_n + 1'b1;
                        if (!line) begin
                            low_seen <= 1'b1;
                            state    <= S_RD_PAD;
                        end else if (poll_n == C_RD_LAST) begin
                            state <= S_RD_PAD;
                        end
                    end
                    S_RD_PAD: if (op_us == C_SLOT) begin
                        state  <= S_IDLE;
                        done   <= 1'b1;
                        result <= !low_seen;
                    end
                    default: state <= S_IDLE;
                endcase
            end
        end
    end

    // Line drive decode: low phases pull down, write recovery and powered idle source high.
    always_comb begin
        pull_low   = (state == S_RST_LOW) || (state == S_WR_LOW) || (state == S_RD_LOW);
        drive_high = ((state == S_IDLE) && powered) || (state == S_WR_HIGH);
    end

endmodule

// File: rtl/swb_master.sv
// Module: single-wire bus master timing engine (top). Connects the 1 us tick
// generator, the input synchronizer and the operation sequencer. Assumes an
// external pull-up on the line and that bus_in reflects the wired level.
module swb_master #(
    parameter int CLK_HZ      = 100_000_000,
    parameter int SYNC_STAGES = 2,
    parameter int T_RST_LOW   = 500,
    parameter int T_PRES_WIN  = 240,
    parameter int T_RECOV     = 450,
    parameter int T_POLL      = 5,
    parameter int T_SHORT     = 2,
    parameter int T_SLOT      = 64,
    parameter int T_RD_WIN    = 45
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    output logic       cmd_ready,
    input  logic [1:0] cmd_op,
    input  logic       cmd_bit,
    output logic       done,
    output logic       result,
    output logic       bus_pull_low,
    output logic       bus_drive_high,
    input  logic       bus_in
);
    logic tick;
    logic start;
    logic line_s;

    swb_tick_gen #(.CLK_HZ(CLK_HZ)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start),
        .tick  (tick)
    );

    swb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_async (bus_in),
        .line_sync  (line_s)
    );

    swb_sequencer #(
        .T_RST_LOW  (T_RST_LOW),
        .T_PRES_WIN (T_PRES_WIN),
        .T_RECOV    (T_RECOV),
        .T_POLL     (T_POLL),
        .T_SHORT    (T_SHORT),
        .T_SLOT     (T_SLOT),
        .T_RD_WIN   (T_RD_WIN)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .line       (line_s),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .cmd_bit    (cmd_bit),
        .cmd_ready  (cmd_ready),
        .start      (start),
        .pull_low   (bus_pull_low),
        .drive_high (bus_drive_high),
        .done       (done),
        .result     (result)
    );

endmodule

// File: rtl/swb_master_chk.sv
// Module: protocol checker for swb_master, attached by bind. Observes ports only.
module swb_master_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic       cmd_ready,
    input logic [1:0] cmd_op,
    input logic       done,
    input logic       bus_pull_low,
    input logic       bus_drive_high
);
    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (cmd_ready && !done && !bus_pull_low && !bus_drive_high)); // R1

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_op != 2'b11) |=> !cmd_ready); // R2

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R4

    AST_DONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cmd_ready); // R4

    AST_DONE_LINE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !bus_pull_low); // R5

    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_pull_low && bus_drive_high)); // R8

endmodule

bind swb_master swb_master_chk u_chk (.*);

// File: tb/sim_swb_master.sv
module sim_swb_master;
    localparam int CLK_HZ = 5_000_000;
    localparam int D      = CLK_HZ / 1_000_000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic       cmd_ready;
    logic [1:0] cmd_op = 2'b00;
    logic       cmd_bit = 1'b0;
    logic       done;
    logic       result;
    logic       bus_pull_low;
    logic       bus_drive_high;
    logic       bus_in;
    logic       dev_pull = 1'b0;

    int cyc = 0;
    int ta = 0;
    int dev_ps = 0;
    int dev_pe = 0;
    bit dev_en = 1'b0;
    int low_cnt = 0;
    int high_cnt = 0;
    int done_cnt = 0;
    int errors = 0;
    int checks = 0;
    bit powered_exp = 1'b0;

    always #5 clk = ~clk;

    assign bus_in = !(bus_pull_low || dev_pull);

    swb_master #(.CLK_HZ(CLK_HZ)) u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .cmd_valid      (cmd_valid),
        .cmd_ready      (cmd_ready),
        .cmd_op         (cmd_op),
        .cmd_bit        (cmd_bit),
        .done           (done),
        .result         (result),
        .bus_pull_low   (bus_pull_low),
        .bus_drive_high (bus_drive_high),
        .bus_in         (bus_in)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // Device model and drive monitors, all on the falling edge.
    always @(negedge clk) begin
        dev_pull <= dev_en && (cyc - ta >= dev_ps) && (cyc - ta < dev_pe);
        if (!cmd_ready) begin
            low_cnt  = low_cnt + int'(bus_pull_low);
            high_cnt = high_cnt + int'(bus_drive_high);
        end
        if (done) done_cnt = done_cnt + 1;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // First poll index (1..n) whose sample sees the device low, else 0 (R11 offset).
    function automatic int first_hit(input int base_us, input int n, input int ps, input int pe);
        for (int k = 1; k <= n; k++) begin
            int e;
            e = (base_us + 5 * k) * D;
            if (e - 3 >= ps && e - 3 < pe) return k;
        end
        return 0;
    endfunction

    task automatic run_op(input int op, input bit wb, input int ps, input int pe, input bit poke);
        int k, exp_res, exp_lat, exp_low, exp_high, lbits;
        case (op)
            0: begin
                k = first_hit(500, 48, ps, pe);
                exp_res  = (k != 0) ? 1 : 0;
                exp_lat  = ((k != 0) ? (950 + 5 * k) : 1190) * D;
                exp_low  = 500 * D;
                exp_high = 0;
            end
            1: begin
                lbits    = wb ? 2 : 62;
                exp_res  = int'(wb);
                exp_lat  = 64 * D;
                exp_low  = lbits * D;
                exp_high = (64 - lbits) * D;
            end
            default: begin
                k = first_hit(2, 8, ps, pe);
                exp_res  = (k == 0) ? 1 : 0;
                exp_lat  = 64 * D;
                exp_low  = 2 * D;
                exp_high = 0;
            end
        endcase
        @(negedge clk);
        dev_ps = ps; dev_pe = pe; dev_en = (pe > ps);
        ta = cyc + 1;
        low_cnt = 0; high_cnt = 0; done_cnt = 0;
        cmd_valid = 1'b1; cmd_op = 2'(op); cmd_bit = wb;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R2 ready low after accept", int'(cmd_ready), 0);
        if (poke) begin
            repeat (20) @(negedge clk);
            cmd_valid = 1'b1; cmd_op = 2'b10;
            for (int i = 0; i < 4; i++) begin
                @(negedge clk);
                chk("R3 ready stays low while busy", int'(cmd_ready), 0);
            end
            cmd_valid = 1'b0;
        end
        while (!done) @(negedge clk);
        if (op == 0) begin
            chk("R7 reset latency", cyc - ta, exp_lat);
            chk("R6 presence result", int'(result), exp_res);
            chk("R5 reset low length", low_cnt, exp_low);
            chk("R8 no high drive during reset", high_cnt, exp_high);
            powered_exp = 1'b1;
        end else if (op == 1) begin
            chk("R9 write latency", cyc - ta, exp_lat);
            chk("R9 write result", int'(result), exp_res);
            chk("R9 write low length", low_cnt, exp_low);
            chk("R9 write high length", high_cnt, exp_high);
        end else begin
            chk("R10 read latency", cyc - ta, exp_lat);
            chk("R10 read result", int'(result), exp_res);
            chk("R10 read low length", low_cnt, exp_low);
            chk("R8 no high drive during read", high_cnt, exp_high);
        end
        chk("R4 ready with done", int'(cmd_ready), 1);
        @(negedge clk);
        dev_en = 1'b0;
        chk("R4 done one cycle", int'(done), 0);
        chk("R4 single done pulse", done_cnt, 1);
        chk("R8 idle drive state", int'(bus_drive_high), int'(powered_exp));
        if (poke) begin
            repeat (40) @(negedge clk);
            chk("R3 busy command not run", done_cnt, 1);
            chk("R3 line quiet after busy command", int'(bus_pull_low), 0);
        end
    endtask

    initial begin : watchdog
        repeat (190_000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : stim
        int op, ps, pe;
        bit wb;
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after reset", int'(cmd_ready), 1);
        chk("R1 done low after reset", int'(done), 0);
        chk("R1 released after reset", int'(bus_pull_low) + int'(bus_drive_high), 0);

        // Read before any bus reset: idle stays released.
        run_op(2, 1'b0, 0, 0, 1'b0);

        // Code 11 has no effect.
        done_cnt = 0;
        cmd_valid = 1'b1; cmd_op = 2'b11;
        repeat (3) @(negedge clk);
        cmd_valid = 1'b0;
        repeat (30) @(negedge clk);
        chk("R3 code 11 no done", done_cnt, 0);
        chk("R3 code 11 ready", int'(cmd_ready), 1);
        chk("R3 code 11 line", int'(bus_pull_low) + int'(bus_drive_high), 0);

        // Bus reset corner cases.
        run_op(0, 1'b0, 0, 0, 1'b0);
        run_op(0, 1'b0, 500 * D + 2, 500 * D + 300, 1'b0);
        run_op(0, 1'b0, 740 * D - 3, 740 * D + 100, 1'b0);
        run_op(0, 1'b0, 740 * D - 2, 740 * D + 100, 1'b0);

        // Write slots, with a command poked in while busy.
        run_op(1, 1'b1, 0, 0, 1'b1);
        run_op(1, 1'b0, 0, 0, 1'b1);

        // Read slots: covered sample, last-sample boundary, and just past it.
        run_op(2, 1'b0, 9 * D, 30 * D, 1'b0);
        run_op(2, 1'b0, 42 * D - 3, 43 * D, 1'b0);
        run_op(2, 1'b0, 42 * D - 2, 60 * D, 1'b0);
        run_op(2, 1'b0, 0, 0, 1'b0);

        // Constrained random mix.
        for (int n = 0; n < 24; n++) begin
            op = int'($urandom % 3);
            wb = 1'($urandom % 2);
            ps = 0; pe = 0;
            if (op == 0 && ($urandom % 4) != 0) begin
                ps = 480 * D + int'($urandom % (280 * D));
                pe = ps + 1 + int'($urandom % (160 * D));
            end else if (op == 2 && ($urandom % 3) != 0) begin
                ps = 2 + int'($urandom % (55 * D));
                pe = ps + 1 + int'($urandom % (62 * D - ps));
            end
            run_op(op, wb, ps, pe, 1'b0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule